// File: doc/BRIEF.md
# PRBS7 Link Error Monitor

This block watches three received links, each delivering a 10-bit word per clock, and checks every bit against a PRBS7 stream that it predicts from the bits already received on that link. Because the prediction uses only the line's own history, the checker locks onto any phase of the pattern within one word and needs no seed or alignment step. Every predicted bit that does not match the received bit is one error. Each link has its own 8-bit error counter.

Software reads the counters through a small read port. A strobe with an address in one cycle returns the selected counter in the next cycle. The same read empties the counter, so each read reports the errors seen since the previous read. A counter that reaches its top value stays there instead of wrapping. A single enable input starts and pauses counting on all links together.

Top module: `prbs_err_monitor`

## Requirements
- R1: While `rst_n` is low, every error counter and `rd_data` are 0x00.
- R2: Within a word, bit 0 is the earliest bit. Each bit b[n] is predicted as b[n-6] XOR b[n-7], taken from the bits received earlier on the same link. Each mismatching bit adds one to that link's counter, so a word with k mismatches adds k in one cycle.
- R3: The counters for links 0, 1 and 2 sit at addresses 0x0A, 0x0B and 0x0C. A cycle with `rd_strobe` high loads `rd_data` on the next clock edge with the addressed counter's value before clearing, or with 0x00 for any other address. Without a strobe, `rd_data` holds its value.
- R4: A counter stops at 0xFF and never wraps, even when a word adds several errors at once.
- R5: A strobed read of a counter sets that counter to zero at the clock edge that ends the read cycle.
- R6: Errors detected in the cycle of a clearing read are not lost. After that edge the counter equals that cycle's error count rather than zero.
- R7: While `count_en` is 0, errors are not counted and the counters keep their values. A read still clears the counter it addresses.
- R8: The first word after reset only fills the prediction history and adds no errors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Error counting enable for all links |
| rd_strobe | input | 1 | Read request for this cycle |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| rx_words | input | 3x10 | Received word per link, link 0 in the low slice, bit 0 earliest |

## Verification
A clearing read and a new error count can arrive in the same clock cycle on the same link. The counter must return its old value and then restart from the new errors instead of dropping them. The bench provokes this by flipping bits in a link's word in the same cycle that it strobes that link's address. It does this with an ordinary count and again with a saturated counter. It judges the result from two reads in a row: the first must show the count before clearing, and the second must show exactly the number of errors injected in the overlapping cycle. The flip patterns are chosen so that all the errors they cause land within that one word.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  // PRBS7: x^7 + x^6 + 1 -> b[n] = b[n-6] ^ b[n-7]
  localparam int PRBS_LEN = 7;
  localparam int PRBS_TAP = 6;

  // Saturating addition, clamped at lim
  function automatic logic [15:0] sat_add(input logic [15:0] a,
                                          input logic [15:0] b,
                                          input logic [15:0] lim);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s > {1'b0, lim}) return lim;
    return s[15:0];
  endfunction

endpackage

// File: rtl/prbs_lane_check.sv
module prbs_lane_check
  import prbs_mon_pkg::*;
#(
  parameter int WORD_W = 10,
  localparam int ERR_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  output logic [ERR_W-1:0]  err_cnt
);

  localparam int EXT_W = WORD_W + PRBS_LEN;

  logic [PRBS_LEN-1:0] hist;   // hist[0] is the oldest received bit
  logic                primed;
  logic [EXT_W-1:0]    ext;
  logic [ERR_W-1:0]    raw_errs;

  assign ext = {rx_word, hist};

  always_comb begin
    raw_errs = '0;
    for (int i = 0; i < WORD_W; i++) begin
      raw_errs = raw_errs + ERR_W'(ext[i + PRBS_LEN] ^
                                  ext[i + PRBS_LEN - PRBS_TAP] ^
                                  ext[i]);
    end
  end

  assign err_cnt = primed ? raw_errs : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      primed <= 1'b0;
    end else begin
      hist   <= ext[EXT_W-1 -: PRBS_LEN];
      primed <= 1'b1;
    end
  end

endmodule

// File: rtl/sat_clr_counter.sv
module sat_clr_counter
  import prbs_mon_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [15:0] LIMIT = 16'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] inc_sat;

  assign inc_sat = CNT_W'(sat_add(16'(0), 16'(inc), LIMIT));

  always_comb begin
    if (clr)     nxt = en ? inc_sat : '0;
    else if (en) nxt = CNT_W'(sat_add(16'(count), 16'(inc), LIMIT));
    else         nxt = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

endmodule

// File: rtl/cnt_read_port.sv
module cnt_read_port #(
  parameter int          N_LANES   = 3,
  parameter int          CNT_W     = 8,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_strobe,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [N_LANES-1:0][CNT_W-1:0]  counts,
  output logic [N_LANES-1:0]             clr,
  output logic [CNT_W-1:0]               rd_data
);

  logic [CNT_W-1:0] sel;

  for (genvar g = 0; g < N_LANES; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + g);
    assign clr[g] = rd_strobe && (rd_addr == MY_ADDR);
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_LANES; i++)
      if (clr[i]) sel = counts[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_strobe) rd_data <= sel;
  end

endmodule

// File: rtl/prbs_err_monitor.sv
module prbs_err_monitor #(
  parameter int          N_LANES   = 3,
  parameter int          WORD_W    = 10,
  parameter int          CNT_W     = 8,
  parameter int          ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          count_en,
  input  logic                          rd_strobe,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [CNT_W-1:0]              rd_data,
  input  logic [N_LANES-1:0][WORD_W-1:0] rx_words
);

  localparam int ERR_W = $clog2(WORD_W + 1);

  // Named internal events for the checker
  logic [N_LANES-1:0][ERR_W-1:0] lane_err;
  logic [N_LANES-1:0][CNT_W-1:0] lane_cnt;
  logic [N_LANES-1:0]            lane_clr;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    prbs_lane_check #(.WORD_W(WORD_W)) chk_u (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_word (rx_words[g]),
      .err_cnt (lane_err[g])
    );

    sat_clr_counter #(.CNT_W(CNT_W), .INC_W(ERR_W)) cnt_u (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (count_en),
      .clr   (lane_clr[g]),
      .inc   (lane_err[g]),
      .count (lane_cnt[g])
    );
  end

  cnt_read_port #(
    .N_LANES(N_LANES), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) rd_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rd_addr   (rd_addr),
    .counts    (lane_cnt),
    .clr       (lane_clr),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/prbs_err_monitor_chk.sv
module prbs_err_monitor_chk #(
  parameter int N_LANES = 3,
  parameter int CNT_W   = 8,
  parameter int ERR_W   = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          count_en,
  input logic                          rd_strobe,
  input logic [CNT_W-1:0]              rd_data,
  input logic [N_LANES-1:0][ERR_W-1:0] lane_err,
  input logic [N_LANES-1:0][CNT_W-1:0] lane_cnt,
  input logic [N_LANES-1:0]            lane_clr
);

  localparam logic [CNT_W-1:0] TOP = '1;

  for (genvar g = 0; g < N_LANES; g++) begin : g_a
    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_cnt[g] == TOP && !lane_clr[g]) |=> lane_cnt[g] == TOP);

    // R2
    count_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !lane_clr[g]) |=> lane_cnt[g] >= $past(lane_cnt[g]));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !lane_clr[g]) |=> $stable(lane_cnt[g]));

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_clr[g] && !count_en) |=> lane_cnt[g] == '0);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_clr[g] && count_en) |=> lane_cnt[g] == CNT_W'($past(lane_err[g])));

    // R3
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_clr[g] |=> rd_data == $past(lane_cnt[g]));
  end

  // R3
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && lane_clr == '0) |=> rd_data == '0);

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_zero_chk: assert (rd_data == '0 && lane_cnt == '0);
    end
  end

endmodule

bind prbs_err_monitor prbs_err_monitor_chk #(
  .N_LANES(N_LANES), .CNT_W(CNT_W), .ERR_W(ERR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .count_en  (count_en),
  .rd_strobe (rd_strobe),
  .rd_data   (rd_data),
  .lane_err  (lane_err),
  .lane_cnt  (lane_cnt),
  .lane_clr  (lane_clr)
);

// File: tb/prbs_err_monitor_tb_top.sv
module prbs_err_monitor_tb_top;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             count_en;
  logic             rd_strobe;
  logic [7:0]       rd_addr;
  logic [7:0]       rd_data;
  logic [2:0][9:0]  rx_words;

  int checks = 0;
  int fails  = 0;
  bit bits_q[$];

  always #5 clk = ~clk;

  prbs_err_monitor dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_en  (count_en),
    .rd_strobe (rd_strobe),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rx_words  (rx_words)
  );

  typedef struct packed {
    logic       en;
    logic [9:0] m0;
    logic [9:0] m1;
    logic [9:0] m2;
    logic       rd;
    logic [7:0] addr;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  // Flip masks 0x001 -> 3 errors, 0x003 -> 4, 0x005 -> 6, all inside the word
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A, 8'd0, 8'd5},  // R5
    '{1'b1, 10'h001, 10'h000, 10'h000, 1'b0, 8'h00, 8'd0, 8'd3},  // R3
    '{1'b1, 10'h000, 10'h003, 10'h000, 1'b0, 8'h00, 8'd0, 8'd3},
    '{1'b1, 10'h000, 10'h000, 10'h005, 1'b1, 8'h0A, 8'd3, 8'd2},  // R2
    '{1'b1, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A, 8'd0, 8'd5},  // R5
    '{1'b1, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0B, 8'd4, 8'd2},  // R2
    '{1'b0, 10'h000, 10'h000, 10'h001, 1'b1, 8'h0C, 8'd6, 8'd2},
    '{1'b1, 10'h005, 10'h000, 10'h000, 1'b1, 8'h0C, 8'd0, 8'd7},  // R7
    '{1'b1, 10'h001, 10'h000, 10'h000, 1'b1, 8'h0A, 8'd6, 8'd6},  // R6
    '{1'b1, 10'h000, 10'h000, 10'h000, 1'b0, 8'h0A, 8'd6, 8'd3},  // R3 hold
    '{1'b1, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A, 8'd3, 8'd6},  // R6
    '{1'b1, 10'h000, 10'h001, 10'h000, 1'b1, 8'h09, 8'd0, 8'd3},  // R3 unmapped
    '{1'b0, 10'h000, 10'h005, 10'h000, 1'b0, 8'h00, 8'd0, 8'd7},  // R7
    '{1'b0, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0D, 8'd0, 8'd3},
    '{1'b1, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0B, 8'd3, 8'd7}   // R7 frozen
  };

  // Reference stream: b[n] = b[n-6] ^ b[n-7]
  task automatic next_word(output logic [9:0] w);
    for (int i = 0; i < 10; i++) begin
      bit nb;
      nb = bits_q[bits_q.size() - 6] ^ bits_q[bits_q.size() - 7];
      bits_q.push_back(nb);
      w[i] = nb;
    end
  endtask

  task automatic step(input logic en, input logic [9:0] m0, input logic [9:0] m1,
                      input logic [9:0] m2, input logic rd, input logic [7:0] addr);
    logic [9:0] w;
    next_word(w);
    count_en  = en;
    rd_strobe = rd;
    rd_addr   = addr;
    rx_words  = {w ^ m2, w ^ m1, w ^ m0};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // seed, oldest first
    bits_q = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
    rst_n = 1'b0; count_en = 1'b0; rd_strobe = 1'b1; rd_addr = 8'h0A; rx_words = '0;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);

    // R8: first word after reset is enabled but must not count
    rst_n = 1'b1;
    step(1'b1, 10'h000, 10'h000, 10'h000, 1'b0, 8'h00);
    step(1'b0, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A);
    check("R8", rd_data, 8'h00);

    for (int v = 0; v < NV; v++) begin
      step(VEC[v].en, VEC[v].m0, VEC[v].m1, VEC[v].m2, VEC[v].rd, VEC[v].addr);
      check($sformatf("R%0d vec%0d", VEC[v].req, v), rd_data, VEC[v].exp);
    end

    // R4: 43 words x 6 errors = 258, must clamp at 0xFF
    repeat (43) step(1'b1, 10'h005, 10'h000, 10'h000, 1'b0, 8'h00);
    step(1'b1, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0B);
    check("R4 other link", rd_data, 8'h00);
    // R6 at saturation: read plus 6 new errors in the same cycle
    step(1'b1, 10'h005, 10'h000, 10'h000, 1'b1, 8'h0A);
    check("R4", rd_data, 8'hFF);
    step(1'b0, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A);
    check("R6 after saturation", rd_data, 8'h06);
    step(1'b0, 10'h000, 10'h000, 10'h000, 1'b1, 8'h0A);
    check("R5 after saturation", rd_data, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule